// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous Burst Memory

This block produces the word address that a synchronous burst memory array uses. A full base address is captured from `addr_i` whenever either of two start strobes is high: one driven from the processor side and one from the memory-controller side. From then on the block generates the next addresses of the burst on its own. The low `BEAT_W` bits, which are two bits by default and so give a four-beat burst, move forward by one beat in each cycle where `advance_i` is high. The upper bits do not change, so a burst always wraps inside its aligned block.

The stepping order is set by `order_lin_i`, which the block samples at the moment of the load. A high level gives linear order, where the low bits count up modulo the burst length starting from the loaded value. A low level gives interleaved order, where the low bits are the loaded value XORed with the beat count. Low is also the default, and a board leaves this pin tied low when nothing drives it. The burst feature does not have to be used. A system can present a new address on every cycle, and each one comes out in turn.

The address is registered. A value loaded or stepped at a clock edge shows on `addr_o` straight after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `addr_o` is all zeros. The stored order is interleaved and the beat count is zero.
- R2: When `strobe_cpu_i` or `strobe_ctl_i` is high at a rising edge, or both are, `addr_o` equals the `addr_i` of that edge once the edge has passed.
- R3: Linear order: in the n-th advance after a load, the low two bits of `addr_o` are (loaded low bits + n) mod 4. A start of 1 gives 1, 2, 3, 0.
- R4: Interleaved order: in the n-th advance after a load, the low two bits are (loaded low bits) XOR (n mod 4). A start of 1 gives 1, 0, 3, 2. A start of 2 gives 2, 3, 0, 1.
- R5: `order_lin_i` = 1 selects linear order and 0 selects interleaved order. The value is captured only in a load cycle, and a change during a burst has no effect on the burst.
- R6: When a strobe and `advance_i` are both high at the same edge, the load wins. `addr_o` becomes `addr_i` and the beat count restarts at zero.
- R7: When neither strobe nor `advance_i` is high, `addr_o` holds its value.
- R8: Between loads the bits above the low two stay fixed. After four advances the low bits return to the loaded value, so the burst wraps inside its aligned four-word block.
- R9: A load on every consecutive cycle, with no advance, puts each new `addr_i` on `addr_o` one after another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_cpu_i | input | 1 | Processor-side start strobe; loads `addr_i` |
| strobe_ctl_i | input | 1 | Controller-side start strobe; loads `addr_i` |
| advance_i | input | 1 | Steps the burst one beat |
| order_lin_i | input | 1 | 1 = linear, 0 = interleaved; sampled at a load |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Word address to the array |

## Verification
The assertions assume that the strobes, `advance_i` and `order_lin_i` are known 0/1 values at every sampled edge once reset is released. They also assume that `addr_i` is meaningful only in cycles where a strobe is high. The stimulus drives every control to a defined level at each falling edge and puts deliberately unrelated values on `addr_i` and `order_lin_i` during advance and idle cycles. This shows that those values are ignored without ever breaking the input assumption. Reset is applied once in the middle of a burst, and it is held for whole cycles so that the check on the reset value never looks at a partial cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  burst_order_e      order_i,
   output logic [ADDR_W-1:0] base_q,
   output burst_order_e      order_q
);

   initial begin
      assert (ADDR_W >= 2) else $fatal(1, "burst_base_reg: ADDR_W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_INTERLEAVE;
      end else if (load_i) begin
         base_q  <= addr_i;
         order_q <= order_i;
      end
   end

   // R5
   order_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(order_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              advance_i,
   output logic [BEAT_W-1:0] beat_q
);

   initial begin
      assert (BEAT_W >= 1 && BEAT_W <= 8) else $fatal(1, "burst_beat_ctr: BEAT_W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         beat_q <= '0;
      else if (load_i)    beat_q <= '0;
      else if (advance_i) beat_q <= beat_q + 1'b1;
   end

   // R6
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && advance_i) |=> (beat_q == '0));

   // R8
   beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && advance_i) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
   import burst_addr_pkg::*;
#(
   parameter int BEAT_W    = 2,
   parameter bit LIN_ONLY  = 1'b0
) (
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  burst_order_e      order_i,
   output logic [BEAT_W-1:0] low_o
);

   logic [BEAT_W-1:0] lin_w;
   logic [BEAT_W-1:0] ilv_w;

   assign lin_w = start_i + beat_i;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_w[b] = start_i[b] ^ beat_i[b];
   end

   if (LIN_ONLY) begin : g_lin_only
      logic unused_ord;
      assign unused_ord = (order_i == ORD_LINEAR) ^ (|ilv_w);
      assign low_o = lin_w;
   end else begin : g_select
      always_comb begin
         if (order_i == ORD_LINEAR) low_o = lin_w;
         else                       low_o = ilv_w;
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_cpu_i,
   input  logic              strobe_ctl_i,
   input  logic              advance_i,
   input  logic              order_lin_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int UP_W = ADDR_W - BEAT_W;

   initial begin
      assert (ADDR_W > BEAT_W) else $fatal(1, "burst_addr_gen: ADDR_W must exceed BEAT_W");
   end

   logic              load_w;
   logic [ADDR_W-1:0] base_q;
   burst_order_e      order_q;
   burst_order_e      order_in;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low_w;

   assign load_w   = strobe_cpu_i | strobe_ctl_i;
   assign order_in = order_lin_i ? ORD_LINEAR : ORD_INTERLEAVE;

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .addr_i(addr_i),
      .order_i(order_in), .base_q(base_q), .order_q(order_q)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .advance_i(advance_i),
      .beat_q(beat_q)
   );

   burst_seq_map #(.BEAT_W(BEAT_W), .LIN_ONLY(1'b0)) u_map (
      .start_i(base_q[BEAT_W-1:0]), .beat_i(beat_q), .order_i(order_q),
      .low_o(low_w)
   );

   assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_w};

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (addr_o == '0));

   // R2
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_w |=> (addr_o == $past(addr_i)));

   // R3
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_w && advance_i && order_q == ORD_LINEAR) |=>
         (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_w && !advance_i) |=> $stable(addr_o));

   // R8
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_w |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

   logic [UP_W-1:0] unused_up;
   assign unused_up = '0;

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

   localparam int AW = 18;
   localparam int NV = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_cpu = 1'b0, s_ctl = 1'b0, adv = 1'b0, lin = 1'b0;
   logic [AW-1:0] a_in = '0;
   logic [AW-1:0] a_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .strobe_cpu_i(s_cpu), .strobe_ctl_i(s_ctl),
      .advance_i(adv), .order_lin_i(lin), .addr_i(a_in), .addr_o(a_out)
   );

   // {req[3:0], cpu, ctl, adv, lin, addr_i[17:0], expected[17:0]}
   localparam logic [43:0] VEC [NV] = '{
      {4'd2, 4'b1001, 18'h00101, 18'h00101},  // R2 cpu load, linear
      {4'd3, 4'b0011, 18'h3FFFF, 18'h00102},  // R3
      {4'd3, 4'b0011, 18'h2AAAA, 18'h00103},  // R3
      {4'd5, 4'b0010, 18'h15555, 18'h00100},  // R5 order change ignored
      {4'd8, 4'b0011, 18'h00000, 18'h00101},  // R8 wraps to start
      {4'd7, 4'b0000, 18'h3FFFF, 18'h00101},  // R7 hold
      {4'd6, 4'b0110, 18'h2A5B5, 18'h2A5B5},  // R6 ctl load beats advance
      {4'd4, 4'b0011, 18'h00000, 18'h2A5B4},  // R4 1^1
      {4'd4, 4'b0011, 18'h00000, 18'h2A5B7},  // R4 1^2
      {4'd4, 4'b0011, 18'h00000, 18'h2A5B6},  // R4 1^3
      {4'd8, 4'b0011, 18'h00000, 18'h2A5B5},  // R8
      {4'd2, 4'b1000, 18'h12342, 18'h12342},  // R2 interleaved start 2
      {4'd4, 4'b0010, 18'h00000, 18'h12343},  // R4
      {4'd7, 4'b0001, 18'h00000, 18'h12343},  // R7
      {4'd4, 4'b0011, 18'h00000, 18'h12340},  // R4
      {4'd2, 4'b1101, 18'h0FFFF, 18'h0FFFF},  // R2 both strobes
      {4'd8, 4'b0010, 18'h00000, 18'h0FFFC},  // R8 upper fixed on wrap
      {4'd9, 4'b0101, 18'h00000, 18'h00000},  // R9
      {4'd9, 4'b1000, 18'h3FFFE, 18'h3FFFE},  // R9
      {4'd9, 4'b0101, 18'h15556, 18'h15556},  // R9
      {4'd3, 4'b0010, 18'h00000, 18'h15557}   // R3 after back-to-back loads
   };

   task automatic check(input int req, input logic [AW-1:0] exp);
      checks++;
      if (a_out !== exp) begin
         fails++;
         $display("FAIL R%0d: addr_o=%h expected %h", req, a_out, exp);
      end
   endtask

   initial begin : watchdog
      repeat (10000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(1, '0);                        // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1, '0);                        // R1 after release

      for (int i = 0; i < NV; i++) begin
         {s_cpu, s_ctl, adv, lin} = VEC[i][39:36];
         a_in = VEC[i][35:18];
         @(negedge clk);
         check(int'(VEC[i][43:40]), VEC[i][17:0]);
      end

      // R1 reset in mid-burst, then default interleaved from zero
      s_cpu = 1'b1; s_ctl = 1'b0; adv = 1'b0; lin = 1'b1; a_in = 18'h0ABCD;
      @(negedge clk);
      s_cpu = 1'b0; adv = 1'b1;
      @(negedge clk);
      check(3, 18'h0ABCE);                 // R3 linear step from 1
      rst_n = 1'b0; adv = 1'b1;
      @(negedge clk);
      check(1, '0);                        // R1 reset beats advance
      rst_n = 1'b1; adv = 1'b1;
      @(negedge clk);
      check(4, 18'h00001);                 // R4 0^1 after reset
      adv = 1'b1;
      @(negedge clk);
      check(4, 18'h00002);                 // R4 0^2
      adv = 1'b0;
      @(negedge clk);
      check(7, 18'h00002);                 // R7

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule